// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Interrupt

This block sits beside a real-time clock's seconds, minutes and hours counters. It keeps three alarm registers, one for each of those counters, and compares them all the time against the live counter values. When all three fields become equal, the block records an alarm event and pulls an active-low interrupt line low. A periodic clock tick can also raise the same interrupt. A small status register records which of the two sources fired. Reading that register clears it and releases the line.

The three time fields share bus addresses with the counters. A steering bit in the control register picks the destination of each write at those addresses. With the bit set, the write loads the alarm register and arms the alarm. With the bit clear, the write is passed on to the external counter through a one-hot write strobe, and the alarm is disarmed. Reads at those addresses always return the live counter values. The alarm registers cannot be read back.

Top module: `tod_alarm_irq`

## Requirements
- R1: After reset, irq_n is 1, the control register reads 8'h00, the status register reads 8'h00, and the alarm is disarmed.
- R2: A write to address 0 (seconds), 1 (minutes) or 2 (hours) while control bit 3 is 1 loads that alarm register, arms the alarm, and leaves ctr_wr at 3'b000.
- R3: A write to address 0, 1 or 2 while control bit 3 is 0 drives ctr_wr one-hot (bit 0 seconds, bit 1 minutes, bit 2 hours) with ctr_wdata equal to the bus data, in the same cycle as the write, and disarms the alarm.
- R4: A read at address 0, 1 or 2 returns cur_sec, cur_min or cur_hr respectively, whatever the value of control bit 3 or the alarm registers.
- R5: While armed, the cycle in which all three counter inputs become equal to the alarm registers sets status bit 0 at the next clock edge, which drives irq_n to 0. If only some of the fields match, nothing is set.
- R6: A match that is held over many cycles raises status bit 0 only once. A new alarm event needs the equality to drop and then return.
- R7: While the alarm is disarmed, a full match sets no status bit and leaves irq_n at 1.
- R8: A clkout_tick pulse sets status bit 1 and drives irq_n to 0 when control bit 0 is 1. When control bit 0 is 0, the pulse has no effect.
- R9: A read at address 4 returns {6'b0, clock bit, alarm bit} and clears both bits at the clock edge that ends the read, so irq_n returns to 1. An event that arrives in the same cycle as the read is kept.
- R10: Address 5 holds the 8-bit control register. It can be read and written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cur_sec | input | 8 | Live seconds counter value |
| cur_min | input | 8 | Live minutes counter value |
| cur_hr | input | 8 | Live hours counter value |
| clkout_tick | input | 1 | Periodic clock-output pulse |
| ctr_wr | output | 3 | One-hot write strobe to the external counters |
| ctr_wdata | output | 8 | Data for the external counters |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The comparator is driven in four ways:
- With two of the three fields matching. This separates a full match from a partial one.
- With a match held for several cycles and then broken and restored. This separates edge detection from level detection.
- With the same match while the alarm is disarmed by a counter write. This shows that the side effect of the steering bit really gates the alarm.
- With clock ticks under both settings of their enable, including one that lands in the same cycle as a status read. This shows that the read clears the status and that a coinciding event is not lost.

Writes with both settings of the steering bit, each followed by read-back, show that the alarm registers never appear on the read path.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    localparam int ADDR_W = 3;
    localparam int CTRL_STEER_BIT = 3;
    localparam int CTRL_CLKIE_BIT = 0;

    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd5;

    typedef struct packed {
        logic clk_src;
        logic alarm_src;
    } irq_stat_t;

    function automatic logic is_time_addr(input logic [ADDR_W-1:0] a, input int nf);
        return int'(a) < nf;
    endfunction

endpackage

// File: rtl/tod_alarm_regif.sv
module tod_alarm_regif
    import tod_alarm_pkg::*;
#(
    parameter int FW = 8,
    parameter int NF = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FW-1:0]      wdata,
    output logic [NF*FW-1:0]   alarm_vec,
    output logic               alarm_en,
    output logic [FW-1:0]      ctrl,
    output logic [NF-1:0]      ctr_wr
);

    logic steer;
    assign steer = ctrl[CTRL_STEER_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && addr == ADR_CTRL) begin
            ctrl <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_en <= 1'b0;
        end else if (wr_en && is_time_addr(addr, NF)) begin
            alarm_en <= steer;
        end
    end

    for (genvar g = 0; g < NF; g++) begin : g_field
        logic sel;
        assign sel = wr_en && (int'(addr) == g);
        assign ctr_wr[g] = sel && !steer;

        always_ff @(posedge clk) begin
            if (rst) begin
                alarm_vec[g*FW +: FW] <= '0;
            end else if (sel && steer) begin
                alarm_vec[g*FW +: FW] <= wdata;
            end
        end
    end

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match #(
    parameter int FW = 8,
    parameter int NF = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NF*FW-1:0] time_vec,
    input  logic [NF*FW-1:0] alarm_vec,
    input  logic             alarm_en,
    output logic             eq,
    output logic             eq_q,
    output logic             hit
);

    logic [NF-1:0] field_eq;

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        assign field_eq[g] = time_vec[g*FW +: FW] == alarm_vec[g*FW +: FW];
    end

    assign eq = &field_eq;

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b1;
        else     eq_q <= eq;
    end

    assign hit = eq && !eq_q && alarm_en;

endmodule

// File: rtl/tod_alarm_status.sv
module tod_alarm_status
    import tod_alarm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      alarm_hit,
    input  logic      clk_hit,
    input  logic      clr,
    output irq_stat_t stat
);

    irq_stat_t nxt;

    always_comb begin
        nxt = clr ? '0 : stat;
        if (alarm_hit) nxt.alarm_src = 1'b1;
        if (clk_hit)   nxt.clk_src   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= nxt;
    end

endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq
    import tod_alarm_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FW-1:0]     bus_wdata,
    output logic [FW-1:0]     bus_rdata,
    input  logic [FW-1:0]     cur_sec,
    input  logic [FW-1:0]     cur_min,
    input  logic [FW-1:0]     cur_hr,
    input  logic              clkout_tick,
    output logic [2:0]        ctr_wr,
    output logic [FW-1:0]     ctr_wdata,
    output logic              irq_n
);

    localparam int NF = 3;

    logic [NF*FW-1:0] time_vec;
    logic [NF*FW-1:0] alarm_vec;
    logic             alarm_en;
    logic [FW-1:0]    ctrl;
    logic             eq, eq_q, alarm_hit, clk_hit, stat_clr;
    irq_stat_t        stat;

    assign time_vec  = {cur_hr, cur_min, cur_sec};
    assign ctr_wdata = bus_wdata;

    tod_alarm_regif #(.FW(FW), .NF(NF)) u_regif (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .alarm_vec(alarm_vec), .alarm_en(alarm_en), .ctrl(ctrl), .ctr_wr(ctr_wr)
    );

    tod_alarm_match #(.FW(FW), .NF(NF)) u_match (
        .clk(clk), .rst(rst), .time_vec(time_vec), .alarm_vec(alarm_vec),
        .alarm_en(alarm_en), .eq(eq), .eq_q(eq_q), .hit(alarm_hit)
    );

    assign clk_hit  = clkout_tick && ctrl[CTRL_CLKIE_BIT];
    assign stat_clr = bus_rd && bus_addr == ADR_STAT;

    tod_alarm_status u_status (
        .clk(clk), .rst(rst), .alarm_hit(alarm_hit), .clk_hit(clk_hit),
        .clr(stat_clr), .stat(stat)
    );

    assign irq_n = !(stat.alarm_src || stat.clk_src);

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NF; i++) begin
            if (int'(bus_addr) == i) bus_rdata = time_vec[i*FW +: FW];
        end
        if (bus_addr == ADR_STAT) bus_rdata = FW'(stat);
        if (bus_addr == ADR_CTRL) bus_rdata = ctrl;
    end

endmodule

// File: rtl/tod_alarm_irq_chk.sv
module tod_alarm_irq_chk
    import tod_alarm_pkg::*;
#(
    parameter int FW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              clkout_tick,
    input logic [2:0]        ctr_wr,
    input logic              irq_n,
    input logic [FW-1:0]     ctrl,
    input logic              alarm_en,
    input logic              eq,
    input logic              eq_q,
    input logic              alarm_hit,
    input logic              stat_alarm
);

    // R3: at most one counter strobe at a time
    a_r3_ctr_wr_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctr_wr));

    // R2: a counter strobe never fires while writes are steered to the alarm
    a_r2_no_strobe_when_steered: assert property (@(posedge clk) disable iff (rst)
        (ctr_wr != 3'b000) |-> !ctrl[CTRL_STEER_BIT]);

    // R7: the alarm status only rises from an armed rising-equality cycle
    a_r7_alarm_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_alarm) |-> ($past(alarm_en) && $past(eq) && !$past(eq_q)));

    // R5: an alarm hit pulls the interrupt low on the next cycle
    a_r5_hit_irq: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |=> !irq_n);

    // R8: an enabled clock tick pulls the interrupt low on the next cycle
    a_r8_tick_irq: assert property (@(posedge clk) disable iff (rst)
        (clkout_tick && ctrl[CTRL_CLKIE_BIT]) |=> !irq_n);

    // R9: a status read with no new event releases the interrupt
    a_r9_read_release: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADR_STAT && !alarm_hit &&
         !(clkout_tick && ctrl[CTRL_CLKIE_BIT])) |=> irq_n);

endmodule

bind tod_alarm_irq tod_alarm_irq_chk #(.FW(FW)) u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .clkout_tick(clkout_tick), .ctr_wr(ctr_wr), .irq_n(irq_n), .ctrl(ctrl),
    .alarm_en(alarm_en), .eq(eq), .eq_q(eq_q), .alarm_hit(alarm_hit),
    .stat_alarm(stat.alarm_src)
);

// File: tb/tod_alarm_irq_tb.sv
module tod_alarm_irq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0;
    logic       clkout_tick = 1'b0;
    logic [2:0] ctr_wr;
    logic [7:0] ctr_wdata;
    logic       irq_n;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tod_alarm_irq u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cur_sec(cur_sec),
        .cur_min(cur_min), .cur_hr(cur_hr), .clkout_tick(clkout_tick),
        .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hr = h;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq_n", irq_n, 1);
        rd(3'd5, d); check("R1 ctrl", d, 8'h00);
        rd(3'd4, d); check("R1 status", d, 8'h00);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        wr(3'd5, 8'hA6); rd(3'd5, d); check("R10 ctrl readback", d, 8'hA6);
        wr(3'd5, 8'h00); rd(3'd5, d); check("R10 ctrl zero", d, 8'h00);
    endtask

    task automatic t_counter_write();
        logic [7:0] d;
        wr(3'd5, 8'h00);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h42;
        #1 check("R3 strobe min", ctr_wr, 3'b010);
        check("R3 wdata", ctr_wdata, 8'h42);
        bus_addr = 3'd2;
        #1 check("R3 strobe hr", ctr_wr, 3'b100);
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check("R3 strobe idle", ctr_wr, 3'b000);
        cur_min = 8'h33;
        rd(3'd1, d); check("R4 read min", d, 8'h33);
    endtask

    task automatic t_latch_write();
        logic [7:0] d;
        wr(3'd5, 8'h08);
        cur_sec = 8'h10;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h15;
        #1 check("R2 no strobe", ctr_wr, 3'b000);
        @(negedge clk);
        bus_wr = 1'b0;
        wr(3'd1, 8'h30);
        wr(3'd2, 8'h07);
        rd(3'd0, d); check("R4 read sec not latch", d, 8'h10);
    endtask

    task automatic t_match();
        logic [7:0] d;
        set_time(8'h15, 8'h30, 8'h08);
        repeat (3) @(negedge clk);
        check("R5 partial no irq", irq_n, 1);
        set_time(8'h15, 8'h30, 8'h07);
        @(negedge clk);
        check("R5 full match irq", irq_n, 0);
        rd(3'd4, d); check("R9 status alarm", d, 8'h01);
        check("R9 released", irq_n, 1);
        repeat (5) @(negedge clk);
        check("R6 held match single", irq_n, 1);
        set_time(8'h16, 8'h30, 8'h07);
        set_time(8'h15, 8'h30, 8'h07);
        @(negedge clk);
        check("R6 new edge irq", irq_n, 0);
        rd(3'd4, d); check("R6 status again", d, 8'h01);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        set_time(8'h00, 8'h00, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h00);
        set_time(8'h15, 8'h30, 8'h07);
        repeat (3) @(negedge clk);
        check("R7 disabled no irq", irq_n, 1);
        rd(3'd4, d); check("R7 status clear", d, 8'h00);
    endtask

    task automatic t_clock();
        logic [7:0] d;
        wr(3'd5, 8'h00);
        @(negedge clk); clkout_tick = 1'b1;
        @(negedge clk); clkout_tick = 1'b0;
        check("R8 tick masked", irq_n, 1);
        wr(3'd5, 8'h01);
        @(negedge clk); clkout_tick = 1'b1;
        @(negedge clk); clkout_tick = 1'b0;
        check("R8 tick irq", irq_n, 0);
        rd(3'd4, d); check("R8 status clock", d, 8'h02);
        check("R9 clock released", irq_n, 1);
    endtask

    task automatic t_coincide();
        logic [7:0] d;
        @(negedge clk); clkout_tick = 1'b1;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'd4;
        #1 d = bus_rdata;
        check("R9 read during tick", d, 8'h02);
        @(negedge clk);
        bus_rd = 1'b0; clkout_tick = 1'b0;
        check("R9 coinciding kept", irq_n, 0);
        rd(3'd4, d); check("R9 kept status", d, 8'h02);
        check("R9 final release", irq_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_counter_write();
        t_latch_write();
        t_match();
        t_disabled();
        t_clock();
        t_coincide();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule